// File: doc/BRIEF.md
# Cascaded Prediction-Marker Sequence Matcher

The block recognises symbol strings against a set of stored templates, all of them at once. Each template is an ordered list of symbol codes and keeps a pointer to the element it expects next. Every incoming symbol is compared in a single cycle with the expected element of every template. A template whose expected element equals the symbol steps its pointer forward. A template whose final element matches is accepted, and its pointer goes back to the start.

Two such matchers are chained. The first level turns a stream of phoneme codes into word numbers. A word number is the index of the first-level template that was accepted. Each word number is then presented to the second level as an input symbol. The second level matches word sequences into concept-sequence identifiers. A second-level template can be flagged as top-level. When such a template is accepted, a completion strobe comes out together with its identifier, and downstream logic uses that strobe to start generation.

Templates are written one element at a time through a load port. A restart strobe puts every pointer back on its first element and throws away any accepts that are still waiting.

Top module: `pm_cascade_matcher`

## Requirements
- R1: After reset or a `restart` pulse, every pointer in both levels is on element 0, `sym_ready` is 1 and `acc_valid` is 0. Any partial progress made before the restart has no effect on later matching.
- R2: A symbol accepted on the input (`sym_valid && sym_ready`) is compared in the same cycle with the expected element of every first-level template. Each template whose element matches and is not flagged last advances its pointer by one. Templates that do not match keep their pointer unchanged.
- R3: When the matching element carries the last flag, the template is accepted and its pointer returns to element 0 for the next symbol.
- R4: When several templates of a level accept on the same symbol, their identifiers leave that level one per cycle, lowest template number first.
- R5: While first-level accepts are still waiting to be handed on, `sym_ready` is 0. It is 0 at the falling clock edge that follows an input symbol causing at least one first-level accept.
- R6: Each first-level accept presents its template number, zero-extended to `SYM_W` bits, to the second level as one input symbol. These symbols arrive in emission order, and each gets the same one-cycle parallel compare as described in R2 and R3.
- R7: Every second-level accept appears once on `acc_valid`/`acc_id`, in order. `acc_top` is 1 with it exactly when that template's top-level flag is 1.
- R8: A load write (`ld_valid`) stores `ld_code` and `ld_last` at element `ld_idx` of template `ld_tpl`, in level `ld_level` (0 = phoneme level, 1 = concept level). It also stores `ld_top` as that template's top-level flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Return all pointers to element 0 and drop waiting accepts |
| ld_valid | input | 1 | Template element write strobe |
| ld_level | input | 1 | Level selected for the write: 0 = phoneme, 1 = concept |
| ld_tpl | input | ID_W | Template number |
| ld_idx | input | IDX_W | Element position inside the template |
| ld_code | input | SYM_W | Symbol code of the element |
| ld_last | input | 1 | Element is the final one of its template |
| ld_top | input | 1 | Template top-level flag |
| sym_valid | input | 1 | Input symbol present |
| sym_code | input | SYM_W | Input phoneme code |
| sym_ready | output | 1 | Input symbol can be taken this cycle |
| acc_valid | output | 1 | Second-level accept strobe (registered) |
| acc_id | output | ID_W | Accepted concept-sequence template number |
| acc_top | output | 1 | Completion strobe: the accepted template is top-level |

## Verification
The interesting coincidence is a second-level compare that happens in the same cycle in which the first level is still draining a burst of simultaneous accepts. Back-pressure between the levels must keep that burst in order while the second level advances and accepts templates of its own. The bench provokes this with templates that share a final phoneme. Both directed and random streams make several words complete on one symbol, and the full ordered list of observed accepts and completion flags is compared against a bench-side two-level reference model. A directed check also confirms that `sym_ready` falls right after such a symbol.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    LVL_PHONE   = 1'b0,
    LVL_CONCEPT = 1'b1
  } level_e;
endpackage

// File: rtl/pm_low_pick.sv
module pm_low_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_level.sv
module pm_level #(
  parameter int NT    = 8,
  parameter int ML    = 4,
  parameter int SYM_W = 5,
  localparam int ID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int IDX_W  = (ML > 1) ? $clog2(ML) : 1,
  localparam int ADDR_W = $clog2(NT * ML)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_tpl,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SYM_W-1:0] wr_code,
  input  logic             wr_last,
  input  logic             wr_top,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_code,
  output logic             in_ready,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id,
  output logic             out_top,
  input  logic             out_pop
);
  logic [SYM_W-1:0] code_mem [NT*ML];
  logic             last_mem [NT*ML];
  logic [NT-1:0]    top_flag;

  logic [NT-1:0][IDX_W-1:0] ptr;
  logic [NT-1:0]            pend;
  logic [NT-1:0]            hit, acc, grant;
  logic [NT-1:0]            cur_last;
  logic                     in_fire;

  logic [ADDR_W-1:0] wr_addr;
  assign wr_addr = ADDR_W'(wr_tpl) * ADDR_W'(ML) + ADDR_W'(wr_idx);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      code_mem[wr_addr] <= wr_code;
      last_mem[wr_addr] <= wr_last;
      top_flag[wr_tpl]  <= wr_top;
    end
  end

  assign in_ready = (pend == '0);
  assign in_fire  = in_valid && in_ready;

  for (genvar t = 0; t < NT; t++) begin : g_tpl
    logic [ADDR_W-1:0] rd_addr;
    assign rd_addr     = ADDR_W'(t) * ADDR_W'(ML) + ADDR_W'(ptr[t]);
    assign cur_last[t] = last_mem[rd_addr];
    assign hit[t]      = in_fire && (code_mem[rd_addr] == in_code);
    assign acc[t]      = hit[t] && cur_last[t];

    always_ff @(posedge clk) begin
      if (rst || restart) begin
        ptr[t] <= '0;
      end else if (hit[t]) begin
        if (cur_last[t] || (32'(ptr[t]) == ML - 1)) ptr[t] <= '0;
        else                                        ptr[t] <= ptr[t] + 1'b1;
      end
    end

    assert_ptr_home_R3: assert property (@(posedge clk) disable iff (rst)
      (acc[t] && !restart) |=> (ptr[t] == '0));
  end

  pm_low_pick #(.N(NT)) i_pick (.req(pend), .idx(out_id), .grant(grant));

  assign out_valid = (pend != '0);
  assign out_top   = top_flag[out_id];

  always_ff @(posedge clk) begin
    if (rst || restart)          pend <= '0;
    else if (in_fire)            pend <= acc;
    else if (out_valid && out_pop) pend <= pend & ~grant;
  end

  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ptr == '0) && (pend == '0) && in_ready);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_fire && !restart) |=> $stable(ptr));

  assert_one_per_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pop && !restart) |=>
      ($countones(pend) == $countones($past(pend)) - 1));
endmodule

// File: rtl/pm_cascade_matcher.sv
module pm_cascade_matcher #(
  parameter int N_TPL   = 8,
  parameter int MAX_LEN = 4,
  parameter int SYM_W   = 5,
  localparam int ID_W  = (N_TPL > 1) ? $clog2(N_TPL) : 1,
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             ld_valid,
  input  logic             ld_level,
  input  logic [ID_W-1:0]  ld_tpl,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [SYM_W-1:0] ld_code,
  input  logic             ld_last,
  input  logic             ld_top,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_code,
  output logic             sym_ready,
  output logic             acc_valid,
  output logic [ID_W-1:0]  acc_id,
  output logic             acc_top
);
  import pm_pkg::*;

  logic            w1_valid, w1_ready, c_valid, c_top, c_unused_ready;
  logic [ID_W-1:0] w1_id, c_id;
  logic            w1_top_unused;

  pm_level #(.NT(N_TPL), .ML(MAX_LEN), .SYM_W(SYM_W)) i_phone (
    .clk(clk), .rst(rst), .restart(restart),
    .wr_en(ld_valid && (level_e'(ld_level) == LVL_PHONE)),
    .wr_tpl(ld_tpl), .wr_idx(ld_idx), .wr_code(ld_code),
    .wr_last(ld_last), .wr_top(ld_top),
    .in_valid(sym_valid), .in_code(sym_code), .in_ready(sym_ready),
    .out_valid(w1_valid), .out_id(w1_id), .out_top(w1_top_unused),
    .out_pop(w1_ready)
  );

  pm_level #(.NT(N_TPL), .ML(MAX_LEN), .SYM_W(SYM_W)) i_concept (
    .clk(clk), .rst(rst), .restart(restart),
    .wr_en(ld_valid && (level_e'(ld_level) == LVL_CONCEPT)),
    .wr_tpl(ld_tpl), .wr_idx(ld_idx), .wr_code(ld_code),
    .wr_last(ld_last), .wr_top(ld_top),
    .in_valid(w1_valid), .in_code(SYM_W'(w1_id)), .in_ready(w1_ready),
    .out_valid(c_valid), .out_id(c_id), .out_top(c_top),
    .out_pop(1'b1)
  );
  assign c_unused_ready = w1_top_unused;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_valid <= 1'b0;
      acc_id    <= '0;
      acc_top   <= 1'b0;
    end else begin
      acc_valid <= c_valid;
      acc_id    <= c_id;
      acc_top   <= c_valid && c_top;
    end
  end

  assert_top_with_accept_R7: assert property (@(posedge clk) disable iff (rst)
    acc_top |-> acc_valid);

  assert_cascade_order_R6: assert property (@(posedge clk) disable iff (rst)
    (w1_valid && !w1_ready && !restart) |=> (w1_valid && $stable(w1_id)));
endmodule

// File: tb/test_pm_cascade_matcher.sv
module test_pm_cascade_matcher;
  localparam int NT = 8, ML = 4, SW = 5;

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
  logic ld_valid = 1'b0, ld_level = 1'b0, ld_last = 1'b0, ld_top = 1'b0;
  logic [2:0] ld_tpl = '0;
  logic [1:0] ld_idx = '0;
  logic [SW-1:0] ld_code = '0, sym_code = '0;
  logic sym_valid = 1'b0, sym_ready, acc_valid, acc_top;
  logic [2:0] acc_id;

  pm_cascade_matcher #(.N_TPL(NT), .MAX_LEN(ML), .SYM_W(SW)) i_pm_cascade_matcher (
    .clk, .rst, .restart, .ld_valid, .ld_level, .ld_tpl, .ld_idx, .ld_code,
    .ld_last, .ld_top, .sym_valid, .sym_code, .sym_ready, .acc_valid,
    .acc_id, .acc_top);

  always #2 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  int m_code [2][NT][ML];
  bit m_last [2][NT][ML];
  bit m_top  [2][NT];
  int m_ptr  [2][NT];
  int exp_q[$];
  int got_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) if (!rst && acc_valid) got_q.push_back(acc_id * 2 + acc_top);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic void model_reset();
    for (int l = 0; l < 2; l++) for (int t = 0; t < NT; t++) m_ptr[l][t] = 0;
  endfunction

  // one parallel compare on level l; returns bitmask of accepting templates
  function automatic int model_step(int l, int code);
    int acc = 0;
    for (int t = 0; t < NT; t++) begin
      if (m_code[l][t][m_ptr[l][t]] == code) begin
        if (m_last[l][t][m_ptr[l][t]]) begin
          acc |= (1 << t);
          m_ptr[l][t] = 0;
        end else m_ptr[l][t] = (m_ptr[l][t] + 1) % ML;
      end
    end
    return acc;
  endfunction

  function automatic int model_symbol(int code);
    int a1 = model_step(0, code);
    for (int t = 0; t < NT; t++) if (a1[t]) begin
      int a2 = model_step(1, t);
      for (int u = 0; u < NT; u++) if (a2[u]) exp_q.push_back(u * 2 + int'(m_top[1][u]));
    end
    return a1;
  endfunction

  task automatic load(int l, int t, int i, int code, bit last, bit top);
    ld_valid = 1; ld_level = l[0]; ld_tpl = t[2:0]; ld_idx = i[1:0];
    ld_code = code[SW-1:0]; ld_last = last; ld_top = top;
    m_code[l][t][i] = code; m_last[l][t][i] = last; m_top[l][t] = top;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic load_tpl(int l, int t, int len, int c0, int c1, int c2, int c3, bit top);
    int cs[4] = '{c0, c1, c2, c3};
    for (int i = 0; i < len; i++) load(l, t, i, cs[i], i == len - 1, top);
  endtask

  task automatic send(int code);
    sym_code = code[SW-1:0];
    sym_valid = 1;
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 0;
  endtask

  task automatic do_restart();
    restart = 1; @(negedge clk); restart = 0;
    model_reset();
    exp_q.delete(); got_q.delete();
  endtask

  task automatic drain_compare(string req);
    repeat (30) @(negedge clk);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
  endtask

  initial begin
    int a;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(sym_ready == 1, "R1 ready after reset", sym_ready, 1);
    check(acc_valid == 0, "R1 no accept after reset", acc_valid, 0);

    // directed program, R8 load port
    load_tpl(0, 0, 2, 1, 2, 0, 0, 0);
    load_tpl(0, 1, 1, 2, 0, 0, 0, 0);
    load_tpl(0, 2, 2, 1, 2, 0, 0, 0);
    for (int t = 3; t < NT; t++) load_tpl(0, t, 1, 9, 0, 0, 0, 0);
    load_tpl(1, 0, 2, 0, 1, 0, 0, 1);
    load_tpl(1, 1, 1, 2, 0, 0, 0, 0);
    load_tpl(1, 2, 2, 1, 2, 0, 0, 0);
    for (int t = 3; t < NT; t++) load_tpl(1, t, 1, 30, 0, 0, 0, 0);
    do_restart();

    // R2 nonmatching symbol holds pointers; R3/R4/R5 triple accept on '2'
    a = model_symbol(1); send(1);
    a = model_symbol(5); send(5);
    a = model_symbol(2);
    sym_code = 2; sym_valid = 1;
    @(negedge clk); sym_valid = 0;
    check(sym_ready == 0, "R5 ready low while accepts wait", sym_ready, 0);
    drain_compare("R4 R6 R7 directed order");
    check(got_q.size() == 3 && got_q[0] == 1 && got_q[1] == 2 && got_q[2] == 4,
          "R7 top flag only on template 0", got_q.size(), 3);

    // R3 pointer home: repeating the word accepts again
    got_q.delete(); exp_q.delete();
    a = model_symbol(2); send(2);
    drain_compare("R3 reaccept after return to first element");

    // R1 restart discards partial progress
    do_restart();
    send(1);
    do_restart();
    a = model_symbol(2); send(2);
    drain_compare("R1 restart mid-sequence");

    // random rounds
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < 2; l++)
        for (int t = 0; t < NT; t++) begin
          int len = 1 + int'($urandom_range(0, ML - 1));
          bit top = $urandom_range(0, 1);
          for (int i = 0; i < len; i++)
            load(l, t, i, (l == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, NT - 1)),
                 i == len - 1, top);
        end
      do_restart();
      for (int k = 0; k < 60; k++) begin
        int c = $urandom_range(0, 3);
        a = model_symbol(c);
        send(c);
      end
      drain_compare("R2 R3 R4 R6 R7 random stream");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule